// File: doc/BRIEF.md
# Epoch-Tagged Fetch Redirect Controller

This block is the control core of a two-stage front end in which fetch and execute run decoupled from each other. The fetch side holds the program counter and a one-bit fetch epoch. Whenever there is room, it pushes a record into a small in-order buffer. The record holds the fetched PC, the next PC the predictor expects, and the epoch value at the moment of fetch. The execute side pops records and holds its own one-bit epoch. It receives the resolved branch outcome for the record at the head of the buffer, and it decides whether that record is live or stale and whether the prediction was wrong.

A wrong prediction does not flush anything. Execute flips its epoch and pushes a (source PC, correct next PC) pair into a one-entry bypass queue. Fetch consumes that pair the first time it fires, in the same cycle if it can. It then jumps to the corrected address, flips its own epoch and forwards the pair to the predictor's update port. Every record fetched before the flip carries the old epoch, and execute drops it without effect. The predictor is a separate module behind a query/update port. The default predictor always answers PC+4 and ignores updates. Addresses are 32 bits and word aligned.

Top module: `fetch_redirect_ctrl`

## Requirements
- R1: While reset is high, `fetch_pc` equals the RESET_PC parameter (default 0x100), `fetch_epoch` and `exec_epoch` are 0, `head_valid` is 0, and neither `redirect_valid` nor `upd_valid` is asserted.
- R2: Each buffered record exposes the PC it was fetched at and the prediction made for it. With the default predictor, `head_ppc` equals `head_pc` + 4 for every record, including PCs that were already sent to the update port.
- R3: `fetch_fire` is high exactly when the buffer held fewer than BUF_DEPTH (default 2) records at the start of the cycle. A record is consumed (`exe_commit` or `exe_kill`) exactly when `head_valid` and `exe_ready` are both high. `fetch_pc` holds its value in cycles where fetch does not fire.
- R4: When fetch fires with no redirect pending, the next `fetch_pc` is the predicted PC (current + 4). When a redirect is pending, fetch pulses `upd_valid` with that pair, loads `fetch_pc` from its target on the next cycle, and inverts `fetch_epoch`.
- R5: A consumed record whose epoch differs from the execute epoch is reported on `exe_kill`. It is still removed from the buffer, and it neither commits nor raises a redirect.
- R6: A live record is mispredicted when the resolved next PC differs from its predicted PC. The resolved next PC is `res_target` if `res_taken` is 1 and `head_pc` + 4 otherwise. A taken branch whose target equals PC+4 is not a misprediction, and a not-taken record ignores `res_target`.
- R7: On a misprediction, `redirect_valid` rises in the same cycle, with `redirect_pc` = `head_pc` and `redirect_target` = the resolved next PC. `exec_epoch` is inverted on the following cycle.
- R8: The redirect queue is a bypass: a redirect raised in a cycle in which fetch fires appears on `upd_valid` in that same cycle. A redirect is never raised while another one is still pending.
- R9: The sequence of committed PCs equals the architectural path, starting at RESET_PC and stepping to the resolved next PC of each instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exe_ready | input | 1 | Execute may consume the head record this cycle |
| res_taken | input | 1 | Resolved outcome for the head record: 1 = taken |
| res_target | input | 32 | Resolved target for the head record, used only when taken |
| fetch_pc | output | 32 | PC being fetched this cycle |
| fetch_fire | output | 1 | Fetch pushes a record this cycle |
| fetch_epoch | output | 1 | Current fetch epoch |
| head_valid | output | 1 | Buffer holds at least one record |
| head_pc | output | 32 | PC of the head record |
| head_ppc | output | 32 | Predicted next PC of the head record |
| exe_commit | output | 1 | Head record consumed and live |
| exe_kill | output | 1 | Head record consumed and stale |
| exec_epoch | output | 1 | Current execute epoch |
| redirect_valid | output | 1 | Misprediction redirect raised this cycle |
| redirect_pc | output | 32 | Source PC of the redirect |
| redirect_target | output | 32 | Corrected next PC |
| upd_valid | output | 1 | Predictor update issued this cycle |
| upd_pc | output | 32 | PC sent to the predictor update port |
| upd_target | output | 32 | Target sent to the predictor update port |

## Verification
Commit, kill and redirect are combinational on the head record and the resolved inputs, so they are due in the very cycle the inputs are driven. A redirect reaches `upd_valid` in that same cycle, or in the first later cycle in which fetch fires. The new `fetch_pc` and the flipped epochs are due one clock edge later. The bench drives inputs on the falling edge, samples all outputs one nanosecond later, and then advances its own model by one edge. Each expectation is therefore compared in the cycle it is due and never against a value from the neighbouring cycle. A queue of architectural PCs, built in advance from the branch program, is popped on each commit.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int ADDR_W     = 32;
    localparam int INSN_BYTES = 4;

    typedef logic [ADDR_W-1:0] addr_t;

    // Record travelling from fetch to execute
    typedef struct packed {
        addr_t pc;
        addr_t pred_pc;
        logic  epoch;
    } fetch_rec_t;

    // Correction travelling from execute back to fetch
    typedef struct packed {
        addr_t src_pc;
        addr_t target;
    } redirect_t;

    function automatic addr_t seq_pc(addr_t pc);
        return pc + addr_t'(INSN_BYTES);
    endfunction

    function automatic addr_t resolved_pc(logic taken, addr_t target, addr_t pc);
        return taken ? target : seq_pc(pc);
    endfunction

endpackage

// File: rtl/frc_predictor.sv
module frc_predictor
    import frc_pkg::*;
(
    input  addr_t query_pc,
    output addr_t pred_pc,
    input  logic  upd_valid,
    input  addr_t upd_pc,
    input  addr_t upd_target
);
    // Sequential predictor: always the next word, updates are dropped.
    logic upd_unused;
    assign upd_unused = ^{upd_valid, upd_pc, upd_target};
    assign pred_pc    = seq_pc(query_pc);
endmodule

// File: rtl/frc_pipe_fifo.sv
module frc_pipe_fifo
    import frc_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enq,
    input  fetch_rec_t enq_rec,
    input  logic       deq,
    output logic       not_full,
    output logic       not_empty,
    output fetch_rec_t head_rec
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    fetch_rec_t         mem [DEPTH];
    logic [PTR_W-1:0]   rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0]   count_q;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign not_full  = (count_q != CNT_W'(DEPTH));
    assign not_empty = (count_q != '0);
    assign head_rec  = mem[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (enq) wr_ptr_q <= bump(wr_ptr_q);
            if (deq) rd_ptr_q <= bump(rd_ptr_q);
            case ({enq, deq})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (enq) mem[wr_ptr_q] <= enq_rec;
    end
endmodule

// File: rtl/frc_bypass_fifo.sv
module frc_bypass_fifo
    import frc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enq,
    input  redirect_t enq_data,
    input  logic      deq,
    output logic      can_enq,
    output logic      avail,
    output redirect_t head
);
    logic      held_q;
    redirect_t data_q;

    assign can_enq = !held_q;
    assign avail   = held_q || enq;
    assign head    = held_q ? data_q : enq_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            data_q <= '0;
        end else if (!held_q) begin
            if (enq && !deq) begin
                held_q <= 1'b1;
                data_q <= enq_data;
            end
        end else if (deq) begin
            held_q <= 1'b0;
        end
    end
endmodule

// File: rtl/fetch_redirect_ctrl.sv
module fetch_redirect_ctrl
    import frc_pkg::*;
#(
    parameter logic [31:0] RESET_PC  = 32'h0000_0100,
    parameter int          BUF_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        exe_ready,
    input  logic        res_taken,
    input  logic [31:0] res_target,
    output logic [31:0] fetch_pc,
    output logic        fetch_fire,
    output logic        fetch_epoch,
    output logic        head_valid,
    output logic [31:0] head_pc,
    output logic [31:0] head_ppc,
    output logic        exe_commit,
    output logic        exe_kill,
    output logic        exec_epoch,
    output logic        redirect_valid,
    output logic [31:0] redirect_pc,
    output logic [31:0] redirect_target,
    output logic        upd_valid,
    output logic [31:0] upd_pc,
    output logic [31:0] upd_target
);
    // ---------------- fetch side state ----------------
    addr_t pc_q;
    logic  fepoch_q;
    addr_t pred_pc;

    // ---------------- execute side state ----------------
    logic  eepoch_q;

    // ---------------- buffer and redirect queue wiring ----------------
    fetch_rec_t new_rec, head_rec;
    logic       buf_not_full, buf_not_empty;
    redirect_t  rdr_in, rdr_head;
    logic       rdr_can_enq, rdr_avail, rdr_take;

    logic       exe_fire, rec_live, mispredict;
    addr_t      actual_next;

    // ---------------- fetch ----------------
    assign fetch_fire = buf_not_full;
    assign new_rec    = '{pc: pc_q, pred_pc: pred_pc, epoch: fepoch_q};
    assign rdr_take   = fetch_fire && rdr_avail;

    frc_predictor u_pred (
        .query_pc   (pc_q),
        .pred_pc    (pred_pc),
        .upd_valid  (rdr_take),
        .upd_pc     (rdr_head.src_pc),
        .upd_target (rdr_head.target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= RESET_PC;
            fepoch_q <= 1'b0;
        end else if (fetch_fire) begin
            if (rdr_avail) begin
                pc_q     <= rdr_head.target;
                fepoch_q <= !fepoch_q;
            end else begin
                pc_q     <= pred_pc;
            end
        end
    end

    frc_pipe_fifo #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .enq       (fetch_fire),
        .enq_rec   (new_rec),
        .deq       (exe_fire),
        .not_full  (buf_not_full),
        .not_empty (buf_not_empty),
        .head_rec  (head_rec)
    );

    // ---------------- execute ----------------
    assign exe_fire    = buf_not_empty && exe_ready;
    assign rec_live    = (head_rec.epoch == eepoch_q);
    assign actual_next = resolved_pc(res_taken, res_target, head_rec.pc);
    assign mispredict  = exe_fire && rec_live && (actual_next != head_rec.pred_pc);
    assign rdr_in      = '{src_pc: head_rec.pc, target: actual_next};

    always_ff @(posedge clk) begin
        if (rst) begin
            eepoch_q <= 1'b0;
        end else if (mispredict) begin
            eepoch_q <= !eepoch_q;
        end
    end

    frc_bypass_fifo u_rdr (
        .clk      (clk),
        .rst      (rst),
        .enq      (mispredict),
        .enq_data (rdr_in),
        .deq      (rdr_take),
        .can_enq  (rdr_can_enq),
        .avail    (rdr_avail),
        .head     (rdr_head)
    );

    // ---------------- outputs ----------------
    assign fetch_pc        = pc_q;
    assign fetch_epoch     = fepoch_q;
    assign exec_epoch      = eepoch_q;
    assign head_valid      = buf_not_empty;
    assign head_pc         = head_rec.pc;
    assign head_ppc        = head_rec.pred_pc;
    assign exe_commit      = exe_fire && rec_live;
    assign exe_kill        = exe_fire && !rec_live;
    assign redirect_valid  = mispredict;
    assign redirect_pc     = rdr_in.src_pc;
    assign redirect_target = rdr_in.target;
    assign upd_valid       = rdr_take;
    assign upd_pc          = rdr_head.src_pc;
    assign upd_target      = rdr_head.target;
endmodule

// File: rtl/frc_checker.sv
module frc_checker (
    input logic        clk,
    input logic        rst,
    input logic        fetch_fire,
    input logic [31:0] fetch_pc,
    input logic        fetch_epoch,
    input logic        head_valid,
    input logic [31:0] head_pc,
    input logic [31:0] head_ppc,
    input logic        exe_kill,
    input logic        exec_epoch,
    input logic        redirect_valid,
    input logic        upd_valid,
    input logic [31:0] upd_target,
    input logic        rdr_can_enq
);
    AST_SEQ_PREDICT: assert property (@(posedge clk) disable iff (rst)
        head_valid |-> head_ppc == head_pc + 32'd4); // R2
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fetch_fire |=> $stable(fetch_pc)); // R3
    AST_REDIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> fetch_pc == $past(upd_target)); // R4
    AST_FEPOCH_FLIP: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> fetch_epoch != $past(fetch_epoch)); // R4
    AST_FEPOCH_KEEP: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(fetch_epoch)); // R4
    AST_KILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        exe_kill |-> !redirect_valid); // R5
    AST_EEPOCH_FLIP: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> exec_epoch != $past(exec_epoch)); // R7
    AST_EEPOCH_KEEP: assert property (@(posedge clk) disable iff (rst)
        !redirect_valid |=> $stable(exec_epoch)); // R7
    AST_BYPASS_SAME: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && fetch_fire) |-> upd_valid); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> rdr_can_enq); // R8
endmodule

bind fetch_redirect_ctrl frc_checker chk_i (
    .clk            (clk),
    .rst            (rst),
    .fetch_fire     (fetch_fire),
    .fetch_pc       (fetch_pc),
    .fetch_epoch    (fetch_epoch),
    .head_valid     (head_valid),
    .head_pc        (head_pc),
    .head_ppc       (head_ppc),
    .exe_kill       (exe_kill),
    .exec_epoch     (exec_epoch),
    .redirect_valid (redirect_valid),
    .upd_valid      (upd_valid),
    .upd_target     (upd_target),
    .rdr_can_enq    (rdr_can_enq)
);

// File: tb/fetch_redirect_ctrl_tb_top.sv
`timescale 1ns/1ps
module fetch_redirect_ctrl_tb_top;
    localparam logic [31:0] START_PC = 32'h0000_0100;
    localparam int          DEPTH    = 2;
    localparam int          N_COMMIT = 90;
    localparam int          WDOG     = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        exe_ready;
    logic        res_taken;
    logic [31:0] res_target;
    logic [31:0] fetch_pc, head_pc, head_ppc, redirect_pc, redirect_target, upd_pc, upd_target;
    logic        fetch_fire, fetch_epoch, head_valid, exe_commit, exe_kill, exec_epoch;
    logic        redirect_valid, upd_valid;

    always #2.5 clk = ~clk;

    fetch_redirect_ctrl #(.RESET_PC(START_PC), .BUF_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .exe_ready(exe_ready), .res_taken(res_taken),
        .res_target(res_target), .fetch_pc(fetch_pc), .fetch_fire(fetch_fire),
        .fetch_epoch(fetch_epoch), .head_valid(head_valid), .head_pc(head_pc),
        .head_ppc(head_ppc), .exe_commit(exe_commit), .exe_kill(exe_kill),
        .exec_epoch(exec_epoch), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .redirect_target(redirect_target),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // Branch program: taken flag and target per PC
    function automatic logic prog_taken(logic [31:0] pc);
        case (pc)
            32'h10C, 32'h154, 32'h18C, 32'h19C: return 1'b1;
            default:                            return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] prog_target(logic [31:0] pc);
        case (pc)
            32'h10C: return 32'h140;
            32'h14C: return 32'h200;      // not taken: target must be ignored
            32'h154: return 32'h180;
            32'h18C: return 32'h190;      // taken to PC+4: no misprediction
            32'h19C: return 32'h100;
            default: return 32'hDEAD_0000;
        endcase
    endfunction

    // Scoreboard state
    logic [31:0] exp_commit_q[$];
    logic [31:0] pend_pc_q[$];
    logic [31:0] pend_tgt_q[$];
    int          occ;
    logic [31:0] m_pc;
    logic        m_fep, m_eep;
    int          kills, bypass_hits;

    task automatic fill_path();
        logic [31:0] pc = START_PC;
        for (int i = 0; i < N_COMMIT; i++) begin
            exp_commit_q.push_back(pc);
            pc = prog_taken(pc) ? prog_target(pc) : pc + 32'd4;
        end
    endtask

    task automatic drive(input int cyc);
        if (cyc < 60)        exe_ready = 1'b1;
        else if (cyc < 70)   exe_ready = 1'b0;
        else                 exe_ready = (cyc % 3) != 0;
        res_taken  = head_valid ? prog_taken(head_pc) : 1'b0;
        res_target = head_valid ? prog_target(head_pc) : 32'h0;
    endtask

    task automatic monitor();
        bit          fired, exp_misp, exp_upd, fresh;
        logic [31:0] exp_tgt;
        check(fetch_pc == m_pc, "R4", "fetch_pc", fetch_pc, m_pc);
        check(fetch_epoch == m_fep, "R4", "fetch_epoch", {31'b0, fetch_epoch}, {31'b0, m_fep});
        check(exec_epoch == m_eep, "R7", "exec_epoch", {31'b0, exec_epoch}, {31'b0, m_eep});
        check(fetch_fire == (occ < DEPTH), "R3", "fetch_fire", {31'b0, fetch_fire}, {31'b0, occ < DEPTH});
        check(head_valid == (occ > 0), "R3", "head_valid", {31'b0, head_valid}, {31'b0, occ > 0});
        if (head_valid)
            check(head_ppc == head_pc + 32'd4, "R2", "head_ppc", head_ppc, head_pc + 32'd4);
        fired = exe_commit || exe_kill;
        check(fired == (head_valid && exe_ready), "R3", "consume", {31'b0, fired},
              {31'b0, head_valid && exe_ready});
        if (exe_commit) begin
            check(exp_commit_q.size() > 0, "R9", "commit beyond path", 32'h0, 32'h0);
            if (exp_commit_q.size() > 0) begin
                check(head_pc == exp_commit_q[0], "R9", "committed pc", head_pc, exp_commit_q[0]);
                void'(exp_commit_q.pop_front());
            end
            exp_tgt  = res_taken ? res_target : head_pc + 32'd4;
            exp_misp = exp_tgt != head_pc + 32'd4;
            check(redirect_valid == exp_misp, "R6", "redirect_valid", {31'b0, redirect_valid}, {31'b0, exp_misp});
            if (exp_misp) begin
                check(redirect_pc == head_pc, "R7", "redirect_pc", redirect_pc, head_pc);
                check(redirect_target == exp_tgt, "R7", "redirect_target", redirect_target, exp_tgt);
            end
        end else if (exe_kill) begin
            kills++;
            check(!redirect_valid, "R5", "redirect on killed record", {31'b0, redirect_valid}, 32'h0);
        end else begin
            check(!redirect_valid, "R6", "redirect while idle", {31'b0, redirect_valid}, 32'h0);
        end
        fresh = 1'b0;
        if (redirect_valid) begin
            check(pend_pc_q.size() == 0, "R8", "second pending redirect", pend_pc_q.size(), 32'h0);
            fresh = 1'b1;
            pend_pc_q.push_back(redirect_pc);
            pend_tgt_q.push_back(redirect_target);
        end
        exp_upd = fetch_fire && (pend_pc_q.size() > 0);
        check(upd_valid == exp_upd, fresh ? "R8" : "R4", "upd_valid", {31'b0, upd_valid}, {31'b0, exp_upd});
        if (upd_valid && pend_pc_q.size() > 0) begin
            if (fresh) bypass_hits++;
            check(upd_pc == pend_pc_q[0], "R4", "upd_pc", upd_pc, pend_pc_q[0]);
            check(upd_target == pend_tgt_q[0], "R4", "upd_target", upd_target, pend_tgt_q[0]);
        end
        // advance model across the next rising edge
        if (fetch_fire) begin
            if (upd_valid && pend_pc_q.size() > 0) begin
                m_pc  = pend_tgt_q[0];
                m_fep = !m_fep;
                void'(pend_pc_q.pop_front());
                void'(pend_tgt_q.pop_front());
            end else begin
                m_pc = m_pc + 32'd4;
            end
        end
        if (redirect_valid) m_eep = !m_eep;
        occ = occ + (fetch_fire ? 1 : 0) - (fired ? 1 : 0);
    endtask

    initial begin
        int cyc = 0;
        rst        = 1'b1;
        exe_ready  = 1'b0;
        res_taken  = 1'b0;
        res_target = 32'h0;
        fill_path();
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(fetch_pc == START_PC, "R1", "reset fetch_pc", fetch_pc, START_PC);
        check(!fetch_epoch && !exec_epoch, "R1", "reset epochs", {30'b0, fetch_epoch, exec_epoch}, 32'h0);
        check(!head_valid, "R1", "reset head_valid", {31'b0, head_valid}, 32'h0);
        check(!redirect_valid && !upd_valid, "R1", "reset redirect/update",
              {30'b0, redirect_valid, upd_valid}, 32'h0);
        @(negedge clk);
        rst   = 1'b0;
        occ   = 0;
        m_pc  = START_PC;
        m_fep = 1'b0;
        m_eep = 1'b0;
        kills = 0;
        bypass_hits = 0;
        while (exp_commit_q.size() > 0 && cyc < WDOG) begin
            drive(cyc);
            #1;
            monitor();
            cyc++;
            @(negedge clk);
        end
        if (cyc >= WDOG) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9 watchdog: actual=%0d expected<%0d cycles", cyc, WDOG);
        end
        check(kills > 0, "R5", "stale records killed", kills, 32'h1);
        check(bypass_hits > 0, "R8", "same-cycle bypass seen", bypass_hits, 32'h1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule